// File: doc/BRIEF.md
# Serial Controller FIFO and Threshold Interrupt Unit

This block sits between a host register interface and a serial shift engine. It holds two byte queues: the host writes the outbound queue and the engine drains it, and the engine fills the inbound queue and the host reads it. The shifting itself and the bit clock live elsewhere. The block only queues bytes, reports how full each queue is, and raises one level interrupt.

Three events can raise the interrupt:
- the inbound queue reaches three quarters full;
- the outbound queue falls to a quarter full or less;
- the engine signals that a transfer has finished.

Each event has a sticky status bit and a matching enable bit. Software clears a status bit by writing a one to it. The two threshold bits are re-evaluated on every cycle. If software clears one while its condition still holds, it comes back one cycle later. Software therefore has to service the queue before it clears the bit.

Each queue also has its own flush input. A flush empties that queue in one cycle and leaves the other queue alone.

Top module: `fifo_irq_unit`

## Requirements
- R1: While reset is asserted, the status word, enable word and FIFO-status word all read zero and `irq` is low.
- R2: Each queue is first-in first-out and holds DEPTH (64) bytes. The FIFO-status word carries the inbound count in bits 6:0 and the outbound count in bits 22:16, and all other bits are zero. A count changes in the cycle after the push or pop that causes it.
- R3: A push to a full queue is ignored and leaves the count at 64. A pop from an empty queue is ignored. A host read of an empty inbound queue returns 0x00.
- R4: Status bit 4 sets in the cycle after the inbound count is at least 48 (three quarters of DEPTH). It does not set while the count is below 48.
- R5: Status bit 12 sets in the cycle after the outbound count is at most 16, that is, when the queue is at least three quarters empty. It does not set while the count is above 16.
- R6: Status bit 16 sets in the cycle after an `engDone` pulse and stays set until cleared. A pulse in the same cycle as a clear of bit 16 leaves the bit set.
- R7: A status write clears, in the next cycle, each of bits 4, 12 and 16 that has a one in the written word. Zero bits in the written word change nothing. An all-ones write clears every pending bit. If a threshold condition still holds, its bit sets again one cycle after it was cleared.
- R8: The enable word uses the same bit positions as the status word (4, 12, 16), and its other bits read zero. A write takes effect in the next cycle. `irq` is high exactly when some status bit and its enable bit are both set. Writing zero masks every source.
- R9: `flushTx` empties only the outbound queue, and `flushRx` empties only the inbound queue. The count reads zero in the next cycle.
- R10: `engTxValid` is high when the outbound queue is not empty, and `engTxData` then shows the oldest outbound byte. `engRxPush` writes `engRxData` into the inbound queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxPush | input | 1 | Host writes a byte to the outbound queue |
| hostTxData | input | 8 | Byte for the outbound queue |
| hostRxPop | input | 1 | Host removes the head byte of the inbound queue |
| hostRxData | output | 8 | Head of the inbound queue, 0x00 when empty |
| flushTx | input | 1 | Empty the outbound queue |
| flushRx | input | 1 | Empty the inbound queue |
| enWrite | input | 1 | Write strobe for the enable word |
| enWdata | input | 32 | New enable word |
| stsWrite | input | 1 | Write-one-to-clear strobe for the status word |
| stsWdata | input | 32 | Bits to clear |
| intEnable | output | 32 | Current enable word |
| intStatus | output | 32 | Current status word |
| fifoStatus | output | 32 | Inbound count [6:0], outbound count [22:16] |
| engTxPop | input | 1 | Engine removes the head byte of the outbound queue |
| engTxData | output | 8 | Head of the outbound queue |
| engTxValid | output | 1 | Outbound queue is not empty |
| engRxPush | input | 1 | Engine writes a byte to the inbound queue |
| engRxData | input | 8 | Byte for the inbound queue |
| engDone | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Level interrupt |

## Verification
All counts and the enable word are due one cycle after the input that changes them. A threshold status bit is due one cycle after the count that crosses the threshold, so it lags the causing push or pop by two cycles. `irq` and the head bytes follow the registered state combinationally, with no further delay.

The bench changes inputs one time unit after a rising edge and reads results just after the following edge, or two edges later for threshold bits. Its scoreboard monitor compares head bytes at the falling edge of each cycle in which a pop is driven, before that pop takes effect.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  localparam int REG_W       = 32;
  localparam int RX_FLAG_BIT = 4;
  localparam int TX_FLAG_BIT = 12;
  localparam int DONE_BIT    = 16;
  localparam int RX_CNT_LSB  = 0;
  localparam int TX_CNT_LSB  = 16;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/fiu_fifo.sv
module fiu_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign headData = mem[rdPtr];

  // R3: the control must never push into a full queue or pop an empty one
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == CW'(DEPTH)) |-> !push);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !pop);
  // R9: a flush leaves the queue empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/fiu_datapath.sv
module fiu_datapath
  import fiu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [WIDTH-1:0] txInData,
  input  logic [WIDTH-1:0] rxInData,
  output logic [WIDTH-1:0] txHead,
  output logic [WIDTH-1:0] rxHead,
  output logic [CW-1:0]    txCount,
  output logic [CW-1:0]    rxCount
);
  fiu_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pop(strobes.txPop), .flush(strobes.txFlush),
    .wrData(txInData), .headData(txHead), .count(txCount)
  );

  fiu_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.rxPush), .pop(strobes.rxPop), .flush(strobes.rxFlush),
    .wrData(rxInData), .headData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/fiu_control.sv
module fiu_control
  import fiu_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int RX_HIGH = (3 * DEPTH) / 4,
  localparam int TX_LOW = DEPTH / 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostTxPush,
  input  logic             hostRxPop,
  input  logic             engTxPop,
  input  logic             engRxPush,
  input  logic             flushTx,
  input  logic             flushRx,
  input  logic             engDone,
  input  logic             enWrite,
  input  logic [REG_W-1:0] enWdata,
  input  logic             stsWrite,
  input  logic [REG_W-1:0] stsWdata,
  input  logic [CW-1:0]    txCount,
  input  logic [CW-1:0]    rxCount,
  output fifoStrobes_t     strobes,
  output logic [REG_W-1:0] intEnable,
  output logic [REG_W-1:0] intStatus,
  output logic             irq
);
  localparam logic [REG_W-1:0] SRC_MASK =
    (REG_W'(1) << RX_FLAG_BIT) | (REG_W'(1) << TX_FLAG_BIT) | (REG_W'(1) << DONE_BIT);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic rxHit, txHit;
  logic [REG_W-1:0] condVec, doneVec, clrVec, statusNext;

  assign txFull  = (txCount == CW'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == CW'(DEPTH));
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strobes.txFlush = flushTx;
    strobes.rxFlush = flushRx;
    strobes.txPush  = hostTxPush && !txFull  && !flushTx;
    strobes.txPop   = engTxPop   && !txEmpty && !flushTx;
    strobes.rxPush  = engRxPush  && !rxFull  && !flushRx;
    strobes.rxPop   = hostRxPop  && !rxEmpty && !flushRx;
  end

  assign rxHit = (rxCount >= CW'(RX_HIGH));
  assign txHit = (txCount <= CW'(TX_LOW));

  always_comb begin
    condVec = '0;
    condVec[RX_FLAG_BIT] = rxHit;
    condVec[TX_FLAG_BIT] = txHit;
    doneVec = '0;
    doneVec[DONE_BIT] = engDone;
    clrVec = stsWrite ? (stsWdata & SRC_MASK) : '0;
    // a clear beats a threshold condition for one cycle; a done pulse beats a clear
    statusNext = ((intStatus | condVec) & ~clrVec) | doneVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatus <= '0;
      intEnable <= '0;
    end else begin
      intStatus <= statusNext;
      if (enWrite) intEnable <= enWdata & SRC_MASK;
    end
  end

  assign irq = |(intStatus & intEnable);

  // R4: inbound threshold flag follows the count unless cleared that cycle
  p_rx_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount >= CW'(RX_HIGH)) && !(stsWrite && stsWdata[RX_FLAG_BIT]) |=> intStatus[RX_FLAG_BIT]);
  // R5: outbound threshold flag
  p_tx_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(TX_LOW)) && !(stsWrite && stsWdata[TX_FLAG_BIT]) |=> intStatus[TX_FLAG_BIT]);
  // R6: completion is never lost
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    engDone |=> intStatus[DONE_BIT]);
  // R7: a one written to the completion bit clears it
  p_w1c_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    stsWrite && stsWdata[DONE_BIT] && !engDone |=> !intStatus[DONE_BIT]);
  // R8: irq only rises after an enabled source or an enable change
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (intStatus != '0) && (intEnable != '0));
endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
  import fiu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostTxPush,
  input  logic [WIDTH-1:0] hostTxData,
  input  logic             hostRxPop,
  output logic [WIDTH-1:0] hostRxData,
  input  logic             flushTx,
  input  logic             flushRx,
  input  logic             enWrite,
  input  logic [REG_W-1:0] enWdata,
  input  logic             stsWrite,
  input  logic [REG_W-1:0] stsWdata,
  output logic [REG_W-1:0] intEnable,
  output logic [REG_W-1:0] intStatus,
  output logic [REG_W-1:0] fifoStatus,
  input  logic             engTxPop,
  output logic [WIDTH-1:0] engTxData,
  output logic             engTxValid,
  input  logic             engRxPush,
  input  logic [WIDTH-1:0] engRxData,
  input  logic             engDone,
  output logic             irq
);
  fifoStrobes_t     strobes;
  logic [CW-1:0]    txCount, rxCount;
  logic [WIDTH-1:0] txHead, rxHead;

  fiu_control #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostTxPush(hostTxPush), .hostRxPop(hostRxPop),
    .engTxPop(engTxPop), .engRxPush(engRxPush),
    .flushTx(flushTx), .flushRx(flushRx), .engDone(engDone),
    .enWrite(enWrite), .enWdata(enWdata),
    .stsWrite(stsWrite), .stsWdata(stsWdata),
    .txCount(txCount), .rxCount(rxCount),
    .strobes(strobes), .intEnable(intEnable), .intStatus(intStatus), .irq(irq)
  );

  fiu_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txInData(hostTxData), .rxInData(engRxData),
    .txHead(txHead), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );

  always_comb begin
    fifoStatus = '0;
    fifoStatus[RX_CNT_LSB +: CW] = rxCount;
    fifoStatus[TX_CNT_LSB +: CW] = txCount;
  end

  assign engTxValid = (txCount != '0);
  assign engTxData  = txHead;
  assign hostRxData = (rxCount != '0) ? rxHead : '0;
endmodule

// File: tb/sim_fifo_irq_unit.sv
module sim_fifo_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostTxPush = 0, hostRxPop = 0, flushTx = 0, flushRx = 0;
  logic enWrite = 0, stsWrite = 0, engTxPop = 0, engRxPush = 0, engDone = 0;
  logic [7:0] hostTxData = '0, engRxData = '0;
  logic [31:0] enWdata = '0, stsWdata = '0;
  logic [7:0] hostRxData, engTxData;
  logic [31:0] intEnable, intStatus, fifoStatus;
  logic engTxValid, irq;

  int errors = 0, checks = 0, txModel = 0, rxModel = 0;
  bit finished = 0;
  logic [7:0] txQ[$], rxQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_irq_unit u0 (
    .clk(clk), .rstN(rstN), .hostTxPush(hostTxPush), .hostTxData(hostTxData),
    .hostRxPop(hostRxPop), .hostRxData(hostRxData), .flushTx(flushTx), .flushRx(flushRx),
    .enWrite(enWrite), .enWdata(enWdata), .stsWrite(stsWrite), .stsWdata(stsWdata),
    .intEnable(intEnable), .intStatus(intStatus), .fifoStatus(fifoStatus),
    .engTxPop(engTxPop), .engTxData(engTxData), .engTxValid(engTxValid),
    .engRxPush(engRxPush), .engRxData(engRxData), .engDone(engDone), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  // drivers: update the bench model and the expected-item queues
  task automatic pushTx(input logic [7:0] b);
    hostTxPush = 1; hostTxData = b;
    if (txModel < DEPTH) begin txQ.push_back(b); txModel++; end
    tick(); hostTxPush = 0;
  endtask
  task automatic popTx();
    engTxPop = 1; tick(); engTxPop = 0;
    if (txModel > 0) txModel--;
  endtask
  task automatic pushRx(input logic [7:0] b);
    engRxPush = 1; engRxData = b;
    if (rxModel < DEPTH) begin rxQ.push_back(b); rxModel++; end
    tick(); engRxPush = 0;
  endtask
  task automatic popRx();
    hostRxPop = 1; tick(); hostRxPop = 0;
    if (rxModel > 0) rxModel--;
  endtask
  task automatic writeSts(input logic [31:0] v);
    stsWrite = 1; stsWdata = v; tick(); stsWrite = 0;
  endtask
  task automatic writeEn(input logic [31:0] v);
    enWrite = 1; enWdata = v; tick(); enWrite = 0;
  endtask

  // scoreboard monitor: compares head bytes while a pop is driven
  always @(negedge clk) begin
    if (rstN && engTxPop && txQ.size() > 0) begin
      logic [7:0] e;
      e = txQ.pop_front();
      chk(engTxData == e, "R2/R10 outbound order", {24'b0, engTxData}, {24'b0, e});
    end
    if (rstN && hostRxPop) begin
      logic [7:0] e;
      e = (rxQ.size() > 0) ? rxQ.pop_front() : 8'h00;
      chk(hostRxData == e, "R2/R3 inbound order", {24'b0, hostRxData}, {24'b0, e});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(intStatus == 0 && intEnable == 0, "R1 regs in reset", intStatus | intEnable, 0);
    chk(fifoStatus == 0, "R1 fifo status in reset", fifoStatus, 0);
    chk(irq == 0, "R1 irq in reset", {31'b0, irq}, 0);
    rstN = 1;
    tick();
    chk(intStatus == 32'h1000, "R5 empty outbound flag", intStatus, 32'h1000);
    chk(irq == 0, "R8 masked at reset", {31'b0, irq}, 0);

    for (int i = 0; i < 20; i++) pushTx(8'(i * 7 + 3));
    chk(fifoStatus == 32'h0014_0000, "R2 outbound count field", fifoStatus, 32'h0014_0000);
    chk(engTxValid == 1 && engTxData == 8'd3, "R10 head visible", {23'b0, engTxValid, engTxData}, 32'h103);
    writeSts(32'h1000);
    chk(intStatus[12] == 0, "R7 clear, no reassert above threshold", intStatus, 0);

    for (int i = 0; i < 4; i++) popTx();
    chk(fifoStatus[22:16] == 16 && intStatus[12] == 0, "R5 flag lags count", intStatus, 0);
    tick();
    chk(intStatus[12] == 1, "R5 flag at 16", intStatus, 32'h1000);

    for (int i = 0; i < 16; i++) popTx();
    popTx();
    chk(fifoStatus[22:16] == 0 && engTxValid == 0, "R3 pop empty ignored / R10 valid low",
        {8'b0, fifoStatus[23:0]}, 0);

    for (int i = 0; i < 66; i++) pushTx(8'(i));
    chk(fifoStatus[22:16] == 64, "R3 push full ignored", {25'b0, fifoStatus[22:16]}, 64);
    popTx(); popTx();
    flushTx = 1; tick(); flushTx = 0;
    txQ.delete(); txModel = 0;
    chk(fifoStatus == 0, "R9 outbound flush", fifoStatus, 0);

    for (int i = 0; i < 48; i++) pushRx(8'(i) ^ 8'h5A);
    chk(fifoStatus == 32'd48 && intStatus[4] == 0, "R4 count 48, flag pending", fifoStatus, 48);
    tick();
    chk(intStatus[4] == 1, "R4 inbound flag", intStatus, 32'h1010);
    writeEn(32'hFFFF_FFFF);
    chk(intEnable == 32'h0001_1010, "R8 enable positions", intEnable, 32'h0001_1010);
    writeEn(32'h10);
    chk(irq == 1, "R8 irq from enabled source", {31'b0, irq}, 1);
    writeSts(32'h10);
    chk(intStatus[4] == 0 && irq == 0, "R7 cleared", intStatus, 32'h1000);
    tick();
    chk(intStatus[4] == 1, "R7 reassert while condition holds", intStatus, 32'h1010);
    popRx();
    writeSts(32'h10);
    tick();
    chk(intStatus[4] == 0, "R4 no flag below 48", intStatus, 32'h1000);
    for (int i = 0; i < 47; i++) popRx();
    popRx();
    chk(hostRxData == 0 && fifoStatus == 0, "R3 empty read zero", {24'b0, hostRxData}, 0);

    writeEn(0);
    engDone = 1; tick(); engDone = 0;
    chk(intStatus[16] == 1 && irq == 0, "R6 done set, R8 masked", intStatus, 32'h0001_1000);
    writeEn(32'h0001_0000);
    chk(irq == 1, "R8 done enabled", {31'b0, irq}, 1);
    writeSts(0);
    chk(intStatus[16] == 1, "R7 zero write no effect", intStatus, 32'h0001_1000);
    engDone = 1; stsWrite = 1; stsWdata = 32'h0001_0000; tick(); engDone = 0; stsWrite = 0;
    chk(intStatus[16] == 1, "R6 done wins over clear", intStatus, 32'h0001_1000);
    writeSts(32'hFFFF_FFFF);
    chk(intStatus == 0 && irq == 0, "R7 all ones clear", intStatus, 0);
    tick();
    chk(intStatus == 32'h1000, "R7 outbound flag returns", intStatus, 32'h1000);

    for (int i = 0; i < 3; i++) begin pushTx(8'hA0 + 8'(i)); pushRx(8'hB0 + 8'(i)); end
    flushRx = 1; tick(); flushRx = 0;
    rxQ.delete(); rxModel = 0;
    chk(fifoStatus == 32'h0003_0000, "R9 inbound flush only", fifoStatus, 32'h0003_0000);
    popTx();
    flushTx = 1; tick(); flushTx = 0;
    txQ.delete(); txModel = 0;
    chk(fifoStatus == 0, "R9 outbound flush", fifoStatus, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule